// File: doc/BRIEF.md
# Millisecond Timer Interrupt Unit

This block produces a periodic interrupt request measured in milliseconds. A free-running prescaler divides the core clock into a one-cycle tick every millisecond. Software sets the period by writing a value to a fixed I/O port. Each tick advances a counter, and when the counter reaches the period a timer request is raised and the counter starts again from zero. Writing a period of zero stops the timer.

The block also holds the pending requests of three interrupt sources: the timer, a serial-byte-received event and a keyboard-key event. A request stays pending until the processor signals the end of an instruction. At that point the highest-priority pending source is serviced. The block emits a one-cycle take pulse with the source number and the handler vector (a byte address for the program counter, plus the matching 16-bit-word fetch address), and it clears that source's pending bit.

Top module: `irq_timer_unit`

## Requirements
- R1: After a synchronous active-low reset, the period is zero, no request is pending, `irq_o` and `take_o` are low, and `vec_pc_o` is 0.
- R2: The prescaler emits one tick every `TICK_DIV` clock cycles (100000 by default, which gives 1 ms at 100 MHz), free-running from reset.
- R3: A cycle with `io_wr_i` high and `io_port_i` equal to `TIMER_PORT` (default 129) loads `io_data_i` into the period and clears the millisecond counter. A write to any other port changes nothing.
- R4: While the period is zero, the counter holds and no timer request is ever raised.
- R5: With period P > 0, the counter advances by one on each tick while below P. On the tick where it equals P, a timer request is raised and the counter returns to zero. Requests therefore come every (P+1) ticks, and the first one arrives between P*TICK_DIV+1 and (P+1)*TICK_DIV cycles after the period write.
- R6: A request stays pending, with `irq_o` high, until it is serviced. Servicing happens only in a cycle where `instr_end_i` is high. `instr_end_i` with nothing pending produces no take pulse.
- R7: Servicing gives a one-cycle `take_o` pulse in the cycle after the `instr_end_i` cycle and clears the serviced pending bit. For the timer, `vec_pc_o` is 8 and `vec_fetch_o` is 4.
- R8: Source codes on `take_src_o` are: 0 for the timer, 1 for the serial byte, 2 for the keyboard key. The lower code wins when several are pending. The vector is 8 + 8*code (byte address), and `vec_fetch_o` is that value divided by 2.
- R9: If a source raises a new event in the same cycle its pending bit is serviced, the bit stays set, so that event is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr_i | input | 1 | I/O port write strobe |
| io_port_i | input | PORT_W | I/O port number |
| io_data_i | input | DATA_W | I/O write data (the period in milliseconds) |
| instr_end_i | input | 1 | High in the last cycle of an instruction |
| uart_evt_i | input | 1 | Serial byte received event pulse |
| kbd_evt_i | input | 1 | Keyboard key pressed event pulse |
| irq_o | output | 1 | High while any request is pending |
| take_o | output | 1 | One-cycle pulse when a request is serviced |
| take_src_o | output | 2 | Code of the serviced source |
| vec_pc_o | output | ADDR_W | Handler byte address of the serviced source |
| vec_fetch_o | output | ADDR_W | Handler word fetch address (vec_pc_o / 2) |

## Verification
The bench measures the spacing between timer requests and expects exactly (P+1) ticks. A design that restarted on a count of P-1, or that counted from 1, would be one tick short. It checks that a period of zero and writes to neighbouring ports stay silent; a loose port decode or an enable that ignores zero would raise requests there. It pends all three sources together and expects them serviced timer first, then serial, then keyboard, with the vectors 8, 16 and 24. A reversed priority loop or a wrong stride would show up there. Finally, it raises a serial event in the same cycle that source is serviced and expects the request still pending afterwards. A design that lets the clear win would drop that event.

// File: rtl/mtiu_pkg.sv
// Package for the millisecond timer interrupt unit.
// Holds the source count and the source code enumeration shared by the
// pending controller and the top level. Assumes three interrupt sources.
package mtiu_pkg;

    localparam int NUM_SRC = 3;
    localparam int SRC_W   = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_TIMER = 2'd0,
        SRC_UART  = 2'd1,
        SRC_KBD   = 2'd2
    } irq_src_e;

endpackage

// File: rtl/ms_tick_gen.sv
// Millisecond tick prescaler.
// Divides the core clock by TICK_DIV and raises tick_o for one cycle in
// every TICK_DIV cycles. It runs freely from reset and cannot be started or
// stopped. Assumes TICK_DIV >= 1; with TICK_DIV == 1 the tick is always high.
module ms_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
            logic [CNT_W-1:0] div_q;

            // Purpose: cycle counter that wraps after TICK_DIV cycles.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick_o = (div_q == LAST);

            AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o) else $error("tick lasted more than one cycle"); // R2
        end else begin : g_nodiv
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/ms_period_timer.sv
// Period register and millisecond counter.
// Decodes writes to TIMER_PORT, holds the period, and counts ticks. It raises
// fire_o for one cycle on the tick where the count equals a nonzero period.
// A period write clears the counter and takes priority over a tick in the
// same cycle. Assumes PERIOD_W <= DATA_W.
module ms_period_timer #(
    parameter int DATA_W     = 32,
    parameter int PERIOD_W   = 32,
    parameter int PORT_W     = 8,
    parameter int TIMER_PORT = 129
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              io_wr_i,
    input  logic [PORT_W-1:0] io_port_i,
    input  logic [DATA_W-1:0] io_data_i,
    output logic              fire_o
);

    localparam logic [PORT_W-1:0] PORT_ID = PORT_W'(TIMER_PORT);

    logic                sel;
    logic                enabled;
    logic                below;
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] count_q;

    // Purpose: decode a write to the timer port.
    always_comb begin
        sel = io_wr_i && (io_port_i == PORT_ID);
    end

    // Purpose: qualify counting with a nonzero period and compare the count.
    always_comb begin
        enabled = (period_q != '0);
        below   = (count_q < period_q);
        fire_o  = tick_i && enabled && !below && !sel;
    end

    // Purpose: period register, loaded only through the timer port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (sel) begin
            period_q <= io_data_i[PERIOD_W-1:0];
        end
    end

    // Purpose: millisecond counter; advances on ticks, restarts on match or write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (sel) begin
            count_q <= '0;
        end else if (tick_i && enabled) begin
            if (below) begin
                count_q <= count_q + 1'b1;
            end else begin
                count_q <= '0;
            end
        end
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (count_q == '0) && (period_q == $past(io_data_i[PERIOD_W-1:0])))
        else $error("period write did not load and clear"); // R3
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) && !sel |=> $stable(count_q))
        else $error("counter moved with zero period"); // R4
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q != '0) |-> (count_q <= period_q))
        else $error("counter passed the period"); // R5
    AST_FIRE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (count_q == '0))
        else $error("counter not restarted after match"); // R5

endmodule

// File: rtl/irq_pending_ctrl.sv
// Pending-request holder and boundary arbiter.
// Each source has a sticky pending bit, set by an event pulse. In a cycle with
// instr_end_i high, the lowest-numbered pending source is serviced: its bit
// is cleared, and in the next cycle take_o pulses with the source code and the
// handler vector VEC_BASE + VEC_STRIDE*code. A new event wins over a clear
// of the same bit in the same cycle. Assumes NUM_SRC fits in SRC_W bits.
module irq_pending_ctrl #(
    parameter int NUM_SRC    = 3,
    parameter int SRC_W      = 2,
    parameter int ADDR_W     = 32,
    parameter int VEC_BASE   = 8,
    parameter int VEC_STRIDE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               instr_end_i,
    output logic               irq_o,
    output logic               take_o,
    output logic [SRC_W-1:0]   take_src_o,
    output logic [ADDR_W-1:0]  vec_pc_o,
    output logic [ADDR_W-1:0]  vec_fetch_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr;
    logic [SRC_W-1:0]   grant_idx;
    logic               grant_vld;
    logic               service;
    logic [ADDR_W-1:0]  vec_next;
    logic               take_q;
    logic [SRC_W-1:0]   src_q;
    logic [ADDR_W-1:0]  pc_q;

    // Purpose: fixed-priority pick; scanning downward leaves the lowest index.
    always_comb begin
        grant_idx = '0;
        grant_vld = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant_idx = SRC_W'(i);
                grant_vld = 1'b1;
            end
        end
    end

    // Purpose: service decision, one-hot clear and vector of the granted source.
    always_comb begin
        service  = instr_end_i && grant_vld;
        clr      = '0;
        if (service) begin
            clr[grant_idx] = 1'b1;
        end
        vec_next = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(grant_idx);
    end

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
            // Purpose: sticky pending bit of source s; a new event beats the clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[s] <= 1'b0;
                end else if (evt_i[s]) begin
                    pend_q[s] <= 1'b1;
                end else if (clr[s]) begin
                    pend_q[s] <= 1'b0;
                end
            end
        end
    endgenerate

    // Purpose: register the take pulse, source code and handler vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            src_q  <= '0;
            pc_q   <= '0;
        end else begin
            take_q <= service;
            if (service) begin
                src_q <= grant_idx;
                pc_q  <= vec_next;
            end
        end
    end

    assign irq_o       = |pend_q;
    assign take_o      = take_q;
    assign take_src_o  = src_q;
    assign vec_pc_o    = pc_q;
    assign vec_fetch_o = pc_q >> 1;

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(instr_end_i))
        else $error("take without instruction end"); // R6
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !instr_end_i |=> irq_o)
        else $error("pending request dropped without service"); // R6
    AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && (take_src_o == '0) && !$past(evt_i[0]) |-> !pend_q[0])
        else $error("timer pending bit not cleared"); // R7
    AST_TIMER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && (take_src_o != '0) |-> !$past(pend_q[0]))
        else $error("lower source taken over timer"); // R8
    AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (int'(take_src_o) < NUM_SRC))
        else $error("source code out of range"); // R8
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[1] |=> pend_q[1])
        else $error("serial event lost"); // R9

endmodule

// File: rtl/irq_timer_unit.sv
// Millisecond timer interrupt unit, top level.
// Joins the tick prescaler, the period timer and the pending controller.
// The timer is source 0, the serial-byte event source 1 and the keyboard
// event source 2. Assumes event inputs are synchronous one-cycle pulses and
// instr_end_i is high for exactly the last cycle of each instruction.
module irq_timer_unit
    import mtiu_pkg::*;
#(
    parameter int TICK_DIV   = 100000,
    parameter int DATA_W     = 32,
    parameter int PORT_W     = 8,
    parameter int TIMER_PORT = 129,
    parameter int ADDR_W     = 32,
    parameter int VEC_BASE   = 8,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_i,
    input  logic [PORT_W-1:0] io_port_i,
    input  logic [DATA_W-1:0] io_data_i,
    input  logic              instr_end_i,
    input  logic              uart_evt_i,
    input  logic              kbd_evt_i,
    output logic              irq_o,
    output logic              take_o,
    output logic [1:0]        take_src_o,
    output logic [ADDR_W-1:0] vec_pc_o,
    output logic [ADDR_W-1:0] vec_fetch_o
);

    logic               tick;
    logic               timer_fire;
    logic [NUM_SRC-1:0] evt;

    ms_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ms_period_timer #(
        .DATA_W     (DATA_W),
        .PERIOD_W   (DATA_W),
        .PORT_W     (PORT_W),
        .TIMER_PORT (TIMER_PORT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .io_wr_i   (io_wr_i),
        .io_port_i (io_port_i),
        .io_data_i (io_data_i),
        .fire_o    (timer_fire)
    );

    // Purpose: gather event pulses in source-code order.
    always_comb begin
        evt            = '0;
        evt[SRC_TIMER] = timer_fire;
        evt[SRC_UART]  = uart_evt_i;
        evt[SRC_KBD]   = kbd_evt_i;
    end

    irq_pending_ctrl #(
        .NUM_SRC    (NUM_SRC),
        .SRC_W      (SRC_W),
        .ADDR_W     (ADDR_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .instr_end_i (instr_end_i),
        .irq_o       (irq_o),
        .take_o      (take_o),
        .take_src_o  (take_src_o),
        .vec_pc_o    (vec_pc_o),
        .vec_fetch_o (vec_fetch_o)
    );

endmodule

// File: tb/tb_irq_timer_unit.sv
// Directed bench for the millisecond timer interrupt unit.
module tb_irq_timer_unit;

    localparam int DIV   = 10;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [31:0] io_data = '0;
    logic        instr_end = 1'b0;
    logic        uart_evt = 1'b0;
    logic        kbd_evt = 1'b0;
    logic        irq;
    logic        take;
    logic [1:0]  take_src;
    logic [31:0] vec_pc;
    logic [31:0] vec_fetch;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_timer_unit #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr), .io_port_i(io_port),
        .io_data_i(io_data), .instr_end_i(instr_end), .uart_evt_i(uart_evt),
        .kbd_evt_i(kbd_evt), .irq_o(irq), .take_o(take), .take_src_o(take_src),
        .vec_pc_o(vec_pc), .vec_fetch_o(vec_fetch)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] port, input logic [31:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_data = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // Pulse instr_end for one cycle and capture the take response.
    task automatic service(output bit tk, output int src, output int pc,
                           output int fetch, output bit tk_after);
        @(negedge clk);
        instr_end = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
        tk = take; src = int'(take_src); pc = int'(vec_pc); fetch = int'(vec_fetch);
        @(negedge clk);
        tk_after = take;
    endtask

    task automatic wait_irq(input int maxc, output int at, output bit ok);
        ok = 1'b0; at = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; at = cyc; break; end
        end
    endtask

    task automatic expect_take(input string req, input int esrc);
        bit tk, tka; int src, pc, fe;
        service(tk, src, pc, fe, tka);
        chk(tk, req, tk, 1);
        chk(src == esrc, req, src, esrc);
        chk(pc == 8 + 8 * esrc, req, pc, 8 + 8 * esrc);
        chk(fe == (8 + 8 * esrc) / 2, req, fe, (8 + 8 * esrc) / 2);
        chk(!tka, "R7 one-cycle take", tka, 0);
    endtask

    task automatic t_reset;
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(take == 1'b0, "R1 take after reset", take, 0);
        chk(vec_pc == 0, "R1 vector after reset", vec_pc, 0);
    endtask

    task automatic t_idle_boundary;
        bit tk, tka; int s, p, f;
        service(tk, s, p, f, tka);
        chk(!tk, "R6 no take when idle", tk, 0);
    endtask

    task automatic t_zero_period;
        bit seen = 1'b0;
        for (int i = 0; i < 30 * DIV; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        chk(!seen, "R4 zero period silent", seen, 0);
    endtask

    task automatic t_wrong_port;
        bit seen = 1'b0;
        io_write(8'd130, 32'd1);
        io_write(8'd128, 32'd1);
        for (int i = 0; i < 10 * DIV; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        chk(!seen, "R3 other ports ignored", seen, 0);
    endtask

    task automatic t_interval(input int p);
        int w, r1, r2, r3; bit ok;
        io_write(8'd129, p);
        w = cyc;
        wait_irq(4 * (p + 1) * DIV, r1, ok);
        chk(ok && (r1 - w >= p * DIV + 1) && (r1 - w <= (p + 1) * DIV),
            "R5 first request window", r1 - w, (p + 1) * DIV);
        expect_take("R7 timer vector", 0);
        chk(!irq, "R7 pending cleared", irq, 0);
        wait_irq(4 * (p + 1) * DIV, r2, ok);
        chk(ok && (r2 - r1 == (p + 1) * DIV), "R5 R2 request spacing", r2 - r1, (p + 1) * DIV);
        expect_take("R8 timer code", 0);
        wait_irq(4 * (p + 1) * DIV, r3, ok);
        chk(ok && (r3 - r2 == (p + 1) * DIV), "R5 R2 request spacing", r3 - r2, (p + 1) * DIV);
    endtask

    task automatic t_hold;
        bit dropped = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!irq) dropped = 1'b1;
        end
        chk(!dropped, "R6 request held until boundary", dropped, 0);
        io_write(8'd129, 32'd0);
        expect_take("R7 timer after hold", 0);
        chk(!irq, "R6 single pending bit", irq, 0);
    endtask

    task automatic t_priority;
        @(negedge clk);
        uart_evt = 1'b1; kbd_evt = 1'b1;
        @(negedge clk);
        uart_evt = 1'b0; kbd_evt = 1'b0;
        io_write(8'd129, 32'd1);
        repeat (3 * DIV + 5) @(negedge clk);
        io_write(8'd129, 32'd0);
        chk(irq, "R6 irq with pending", irq, 1);
        expect_take("R8 timer first", 0);
        expect_take("R8 serial second", 1);
        expect_take("R8 keyboard third", 2);
        chk(!irq, "R8 all serviced", irq, 0);
    endtask

    task automatic t_coincide;
        @(negedge clk);
        uart_evt = 1'b1;
        @(negedge clk);
        uart_evt = 1'b0;
        instr_end = 1'b1;
        uart_evt = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
        uart_evt = 1'b0;
        chk(take && take_src == 2'd1, "R9 serviced serial", take_src, 1);
        chk(irq, "R9 new event kept", irq, 1);
        expect_take("R9 kept event serviced", 1);
        chk(!irq, "R9 cleared after second", irq, 0);
    endtask

    task automatic t_rewrite;
        int w, r, r0; bit ok;
        io_write(8'd129, 32'd5);
        wait_irq(10 * DIV, r0, ok);
        expect_take("R5 long period", 0);
        repeat (2 * DIV + 3) @(negedge clk);
        io_write(8'd129, 32'd1);
        w = cyc;
        wait_irq(10 * DIV, r, ok);
        chk(ok && (r - w >= DIV + 1) && (r - w <= 2 * DIV),
            "R3 write restarts count", r - w, 2 * DIV);
        io_write(8'd129, 32'd0);
        expect_take("R7 after rewrite", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_boundary();
        t_zero_period();
        t_wrong_port();
        t_interval(3);
        t_hold();
        t_interval(1);
        io_write(8'd129, 32'd0);
        begin
            bit tk, tka; int s, p, f;
            if (irq) service(tk, s, p, f, tka);
        end
        t_priority();
        t_coincide();
        t_rewrite();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule